// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address order that a synchronous DRAM follows during one read or write burst. A one-cycle start pulse captures the start column, a three-bit burst length code and the ordering select, all taken from the controller's copy of the device mode settings. From the next clock on, the block presents one column per clock until the burst is complete or an abort ends it.

Fixed bursts of 2, 4 and 8 beats wrap inside the naturally aligned block of that length. In sequential order the low bits count up. In interleaved order the low bits are the start bits XORed with the beat number. A full-page burst walks the whole 1024-column space, wraps from the top column to zero, and runs until it is aborted. The block provides only the column order. Command decoding, bank and row state, refresh and data movement belong to other blocks.

Top module: `burst_colgen`

## Requirements
- R1: While reset is asserted and after reset is released with no start, `valid_o` and `last_o` are 0.
- R2: When `start_i` is high at a rising edge, the next cycle shows `valid_o`=1 and `col_o` equal to the sampled `start_col_i`. A start during a running burst replaces that burst.
- R3: Length codes 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats, and code 7 gives full page. Codes 4, 5 and 6 give 1 beat. `valid_o` stays high for exactly the number of beats and then falls.
- R4: With `ilv_i`=0 and a fixed length L, beat n has `col_o` = (start rounded down to a multiple of L) + ((start mod L) + n) mod L.
- R5: With `ilv_i`=1 and a fixed length L, beat n has `col_o` = (start rounded down to a multiple of L) + ((start mod L) XOR n).
- R6: In a full-page burst, `col_o` rises by one on each clock modulo 1024, so column 1023 is followed by 0. The burst continues until aborted, and `ilv_i` has no effect.
- R7: `last_o` is high only together with `valid_o` on the final beat of a fixed-length burst. It never rises during a full-page burst.
- R8: When `abort_i` is high at a rising edge and `start_i` is low, `valid_o` and `last_o` are 0 from the next cycle on. When both are high, the start takes effect. An abort while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle burst start pulse |
| start_col_i | input | 10 | First column of the burst |
| len_code_i | input | 3 | Burst length code (see R3) |
| ilv_i | input | 1 | 1 = interleaved order, 0 = sequential order |
| abort_i | input | 1 | Ends the running burst |
| col_o | output | 10 | Column address of the current beat |
| valid_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | Final beat of a fixed-length burst |

## Verification
Start columns with nonzero low bits near the top of an aligned block are used, so a wrap inside the block can be told apart from a carry into the upper bits. The same start column is run in both orders. This separates addition from XOR, because the two agree only when no carry occurs. A full-page burst is started a few columns below 1023 with the interleave select high, which shows both the wrap to zero and that the select is ignored. The aborts are applied mid-burst, together with a start, and while idle, which separates the priority of start over abort from a plain stop.

// File: rtl/burst_colgen_pkg.sv
package burst_colgen_pkg;

   typedef enum logic {
      ORD_SEQ = 1'b0,
      ORD_ILV = 1'b1
   } order_e;

   typedef struct packed {
      logic       full;
      logic [2:0] log_len;
   } len_dec_t;

   // Decodes the length code into log2 of the beat count or full page.
   function automatic len_dec_t decode_len(input logic [2:0] code,
                                           input int unsigned max_log,
                                           input int unsigned full_code);
      len_dec_t d;
      d.full    = 1'b0;
      d.log_len = 3'd0;
      if (32'(code) == full_code) begin
         d.full = 1'b1;
      end else if (32'(code) <= max_log) begin
         d.log_len = code;
      end
      return d;
   endfunction

endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
   import burst_colgen_pkg::*;
#(
   parameter int unsigned COL_W     = 10,
   parameter int unsigned CODE_W    = 3,
   parameter int unsigned MAX_LOG   = 3,
   parameter int unsigned FULL_CODE = 7
) (
   input  logic [CODE_W-1:0] code_i,
   input  logic              ilv_i,
   output logic [COL_W-1:0]  mask_o,
   output logic              full_o,
   output order_e            order_o
);

   len_dec_t dec;

   always_comb begin
      dec = decode_len(3'(code_i), MAX_LOG, FULL_CODE);
   end

   // Beat mask: low log_len bits set.
   for (genvar b = 0; b < COL_W; b++) begin : g_mask
      if (b < MAX_LOG) begin : g_low
         assign mask_o[b] = (32'(dec.log_len) > b);
      end else begin : g_high
         assign mask_o[b] = 1'b0;
      end
   end

   assign full_o  = dec.full;
   // Interleaving has no meaning across a full page: fall back to sequential.
   assign order_o = (ilv_i && !dec.full) ? ORD_ILV : ORD_SEQ;

endmodule

// File: rtl/burst_beat_seq.sv
module burst_beat_seq #(
   parameter int unsigned COL_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             abort_i,
   input  logic [COL_W-1:0] mask_i,
   input  logic             full_i,
   output logic             active_o,
   output logic [COL_W-1:0] beat_o,
   output logic             final_o
);

   logic             active_q;
   logic [COL_W-1:0] beat_q;
   logic [COL_W-1:0] mask_q;
   logic             full_q;
   logic             at_end;

   assign at_end = !full_q && (beat_q == mask_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         beat_q   <= '0;
         mask_q   <= '0;
         full_q   <= 1'b0;
      end else if (start_i) begin
         active_q <= 1'b1;
         beat_q   <= '0;
         mask_q   <= mask_i;
         full_q   <= full_i;
      end else if (abort_i) begin
         active_q <= 1'b0;
      end else if (active_q) begin
         if (at_end) begin
            active_q <= 1'b0;
         end else begin
            beat_q <= beat_q + 1'b1;
         end
      end
   end

   assign active_o = active_q;
   assign beat_o   = beat_q;
   assign final_o  = active_q && at_end;

endmodule

// File: rtl/burst_addr_form.sv
module burst_addr_form
   import burst_colgen_pkg::*;
#(
   parameter int unsigned COL_W   = 10,
   parameter int unsigned MAX_LOG = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [COL_W-1:0] start_col_i,
   input  logic [COL_W-1:0] mask_i,
   input  logic             full_i,
   input  order_e           order_i,
   input  logic [COL_W-1:0] beat_i,
   output logic [COL_W-1:0] col_o
);

   logic [COL_W-1:0] base_q;
   logic [COL_W-1:0] mask_q;
   logic             full_q;
   order_e           order_q;
   logic [COL_W-1:0] sum_v;
   logic [COL_W-1:0] xor_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q  <= '0;
         mask_q  <= '0;
         full_q  <= 1'b0;
         order_q <= ORD_SEQ;
      end else if (load_i) begin
         base_q  <= start_col_i;
         mask_q  <= mask_i;
         full_q  <= full_i;
         order_q <= order_i;
      end
   end

   // Low bits of a plain sum equal the modulo-L count, as no carry enters them.
   assign sum_v = base_q + beat_i;
   assign xor_v = base_q ^ beat_i;

   for (genvar b = 0; b < COL_W; b++) begin : g_bit
      if (b < MAX_LOG) begin : g_wrap
         always_comb begin
            if (mask_q[b]) begin
               col_o[b] = (order_q == ORD_ILV) ? xor_v[b] : sum_v[b];
            end else begin
               col_o[b] = full_q ? sum_v[b] : base_q[b];
            end
         end
      end else begin : g_fixed
         assign col_o[b] = full_q ? sum_v[b] : base_q[b];
      end
   end

endmodule

// File: rtl/burst_colgen.sv
module burst_colgen
   import burst_colgen_pkg::*;
#(
   parameter int unsigned COL_W     = 10,
   parameter int unsigned CODE_W    = 3,
   parameter int unsigned MAX_LOG   = 3,
   parameter int unsigned FULL_CODE = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [COL_W-1:0]  start_col_i,
   input  logic [CODE_W-1:0] len_code_i,
   input  logic              ilv_i,
   input  logic              abort_i,
   output logic [COL_W-1:0]  col_o,
   output logic              valid_o,
   output logic              last_o
);

   localparam int unsigned MAX_BEATS = 1 << MAX_LOG;

   if (CODE_W != 3) begin : g_chk_code
      $error("burst_colgen: CODE_W must be 3");
   end
   if (MAX_LOG >= COL_W || MAX_BEATS > 64) begin : g_chk_log
      $error("burst_colgen: MAX_LOG out of range");
   end
   if (FULL_CODE <= MAX_LOG || FULL_CODE >= (1 << CODE_W)) begin : g_chk_full
      $error("burst_colgen: FULL_CODE collides with a fixed length");
   end

   logic [COL_W-1:0] mask_d;
   logic             full_d;
   order_e           order_d;
   logic [COL_W-1:0] beat;
   logic             active;
   logic             final_beat;

   burst_len_decode #(
      .COL_W(COL_W), .CODE_W(CODE_W), .MAX_LOG(MAX_LOG), .FULL_CODE(FULL_CODE)
   ) u_dec (
      .code_i (len_code_i),
      .ilv_i  (ilv_i),
      .mask_o (mask_d),
      .full_o (full_d),
      .order_o(order_d)
   );

   burst_beat_seq #(.COL_W(COL_W)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .abort_i (abort_i),
      .mask_i  (mask_d),
      .full_i  (full_d),
      .active_o(active),
      .beat_o  (beat),
      .final_o (final_beat)
   );

   burst_addr_form #(.COL_W(COL_W), .MAX_LOG(MAX_LOG)) u_addr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (start_i),
      .start_col_i(start_col_i),
      .mask_i     (mask_d),
      .full_i     (full_d),
      .order_i    (order_d),
      .beat_i     (beat),
      .col_o      (col_o)
   );

   assign valid_o = active;
   assign last_o  = final_beat;

endmodule

// File: rtl/burst_colgen_chk.sv
module burst_colgen_chk #(
   parameter int unsigned COL_W     = 10,
   parameter int unsigned CODE_W    = 3,
   parameter int unsigned FULL_CODE = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [COL_W-1:0]  start_col_i,
   input logic [CODE_W-1:0] len_code_i,
   input logic              abort_i,
   input logic [COL_W-1:0]  col_o,
   input logic              valid_o,
   input logic              last_o
);

   // Tracks from the ports whether the running burst is full page.
   logic page_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       page_q <= 1'b0;
      else if (start_i) page_q <= (32'(len_code_i) == FULL_CODE);
   end

   p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> !last_o);

   p_start_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (valid_o && col_o == $past(start_col_i)));

   p_done_after_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (last_o && !start_i) |=> !valid_o);

   p_page_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && page_q && !start_i && !abort_i) |=>
         (valid_o && col_o == $past(col_o) + 1'b1));

   p_page_no_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && page_q) |-> !last_o);

   p_last_with_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |-> valid_o);

   p_abort_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_i && !start_i) |=> (!valid_o && !last_o));

endmodule

bind burst_colgen burst_colgen_chk #(
   .COL_W(COL_W), .CODE_W(CODE_W), .FULL_CODE(FULL_CODE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .start_col_i(start_col_i),
   .len_code_i (len_code_i),
   .abort_i    (abort_i),
   .col_o      (col_o),
   .valid_o    (valid_o),
   .last_o     (last_o)
);

// File: tb/burst_colgen_bench.sv
module burst_colgen_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [9:0] start_col_i = '0;
   logic [2:0] len_code_i = '0;
   logic       ilv_i = 1'b0;
   logic       abort_i = 1'b0;
   logic [9:0] col_o;
   logic       valid_o;
   logic       last_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   burst_colgen u_burst_colgen (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
      .len_code_i(len_code_i), .ilv_i(ilv_i), .abort_i(abort_i),
      .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int beats_of(input int code);
      case (code)
         0: return 1;
         1: return 2;
         2: return 4;
         3: return 8;
         default: return 1;
      endcase
   endfunction

   function automatic int exp_col(input int s, input int len, input bit ilv, input int n);
      int base = s - (s % len);
      if (ilv) return base + ((s % len) ^ n);
      return base + (((s % len) + n) % len);
   endfunction

   // Drives a start at a falling edge; returns at the falling edge of beat 0.
   task automatic kick(input int col, input int code, input bit ilv, input bit ab);
      start_col_i = 10'(col);
      len_code_i  = 3'(code);
      ilv_i       = ilv;
      start_i     = 1'b1;
      abort_i     = ab;
      @(negedge clk);
      start_i = 1'b0;
      abort_i = 1'b0;
   endtask

   task automatic t_fixed(input int col, input int code, input bit ilv, input string tag);
      int len = beats_of(code);
      kick(col, code, ilv, 1'b0);
      for (int n = 0; n < len; n++) begin
         chk(valid_o === 1'b1, {tag, " R3 valid"}, int'(valid_o), 1);
         chk(col_o === 10'(exp_col(col, len, ilv, n)), tag, int'(col_o),
             exp_col(col, len, ilv, n));
         chk(last_o === (n == len - 1), {tag, " R7 last"}, int'(last_o), int'(n == len - 1));
         @(negedge clk);
      end
      chk(valid_o === 1'b0, {tag, " R3 end"}, int'(valid_o), 0);
   endtask

   task automatic t_reset;
      chk(valid_o === 1'b0 && last_o === 1'b0, "R1 in reset", int'(valid_o), 0);
      @(negedge clk); rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(valid_o === 1'b0 && last_o === 1'b0, "R1 after reset", int'(valid_o), 0);
   endtask

   task automatic t_page;
      int s = 1020;
      kick(s, 7, 1'b1, 1'b0);
      for (int n = 0; n < 10; n++) begin
         chk(col_o === 10'((s + n) % 1024), "R6 page col", int'(col_o), (s + n) % 1024);
         chk(valid_o === 1'b1 && last_o === 1'b0, "R7 page no last", int'(last_o), 0);
         if (n == 9) abort_i = 1'b1;
         @(negedge clk);
      end
      abort_i = 1'b0;
      chk(valid_o === 1'b0, "R8 page abort", int'(valid_o), 0);
   endtask

   task automatic t_abort_mid;
      kick(12'h0A0, 3, 1'b0, 1'b0);
      @(negedge clk);
      chk(col_o === 10'h0A1, "R4 before abort", int'(col_o), 'h0A1);
      abort_i = 1'b1;
      @(negedge clk);
      abort_i = 1'b0;
      chk(valid_o === 1'b0 && last_o === 1'b0, "R8 mid abort", int'(valid_o), 0);
      @(negedge clk);
      chk(valid_o === 1'b0, "R8 stays idle", int'(valid_o), 0);
   endtask

   task automatic t_restart(input bit with_abort);
      kick(16, 3, 1'b0, 1'b0);
      @(negedge clk);
      kick(12'h105, 1, 1'b0, with_abort);
      chk(valid_o === 1'b1 && col_o === 10'h105, "R2 restart beat0", int'(col_o), 'h105);
      @(negedge clk);
      chk(col_o === 10'h104 && last_o === 1'b1, "R4 restart beat1", int'(col_o), 'h104);
      @(negedge clk);
      chk(valid_o === 1'b0, "R8 restart done", int'(valid_o), 0);
   endtask

   task automatic t_idle_abort;
      abort_i = 1'b1;
      @(negedge clk);
      abort_i = 1'b0;
      chk(valid_o === 1'b0 && last_o === 1'b0, "R8 idle abort", int'(valid_o), 0);
   endtask

   initial begin
      t_reset();
      t_fixed(12'h3F5, 0, 1'b0, "R2 len1");
      t_fixed(12'h3F5, 1, 1'b0, "R4 seq2");
      t_fixed(12'h3F5, 2, 1'b0, "R4 seq4");
      t_fixed(12'h3F5, 3, 1'b0, "R4 seq8");
      t_fixed(12'h2AB, 2, 1'b1, "R5 ilv4");
      t_fixed(12'h2AB, 3, 1'b1, "R5 ilv8");
      t_fixed(12'h2AB, 1, 1'b1, "R5 ilv2");
      t_fixed(12'h2AB, 4, 1'b0, "R3 code4");
      t_fixed(12'h2AB, 5, 1'b1, "R3 code5");
      t_fixed(12'h2AB, 6, 1'b0, "R3 code6");
      t_page();
      t_abort_mid();
      t_restart(1'b0);
      t_restart(1'b1);
      t_idle_abort();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

endmodule